// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is a configuration port of the kind found on legacy I/O controllers. Two byte-wide addresses sit side by side on a simple bus. Address 0 is the index address and address 1 is the data address. The bus has one address bit, a write strobe, a read strobe and write and read data. The port stays closed after reset: reads return 0xFF and writes change nothing. Software opens it by writing an unlock key twice to the index address. Once the port is open, an index write picks an internal register, and data-address accesses read or write that register. Writing the lock key to the index address closes the port again.

The registers are split into two groups. Global registers are always visible: the logical-device number and a read-only chip identification byte. Per-device registers are an activate bit and a few generic bytes. A copy of them exists for every logical device, and the logical-device number picks which copy the data address reaches. Each device's activate bit is driven out on a port so that the device logic can follow it. Logical device 8 is the watchdog bank.

Top module: `keyed_cfg_port`

## Requirements
- R1: While `rst` is high and after it falls, the port is locked. The index register and the logical-device number are 0x00, every bit of `dev_active` is 0, and `bus_rdata` is 0xFF.
- R2: Two writes of 0x87 to address 0, with no other write between them, unlock the port. An access in the very next cycle is already served.
- R3: Any write other than 0x87 to address 0, made between the two key writes, sends the key sequence back to its start. So does any write to address 1. Two fresh 0x87 writes are then needed.
- R4: While the port is locked, reads at either address return 0xFF. Writes other than key writes change no register and no `dev_active` bit.
- R5: While the port is unlocked, a write of 0xAA to address 0 locks it. The index register keeps its previous value, and that value is seen again after the next unlock.
- R6: While the port is unlocked, any other write to address 0 loads the index register, and a read of address 0 returns it.
- R7: Index 0x07 is the logical-device number. It is read/write and all 8 bits are kept.
- R8: Index 0x20 reads as the chip identification byte, parameter `CHIP_ID`, default 0xA5. Writes to it are ignored.
- R9: Index 0x30 of the selected device holds its activate bit in bit 0. Reads return {7'b0, activate}. The bit drives `dev_active[ldn]`, and `dev_active[8]` is the watchdog bank.
- R10: Indexes 0xF0 to 0xF0+NUM_GEN-1 (default 0xF0 to 0xF3) are generic read/write bytes. Every logical device has its own set.
- R11: If the logical-device number is NUM_DEV or more (default 10), per-device reads return 0xFF and per-device writes are ignored. Indexes that map to no register read 0xFF.
- R12: `bus_rdata` is loaded on the clock edge that samples `bus_rd` high. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects the index address, 1 the data address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_active | output | NUM_DEV | Activate bit of each logical device |

## Verification
Each write, including a key or lock write, takes effect on the clock edge that samples its strobe. The next access may therefore be driven in the following cycle, and `dev_active` is compared one half cycle after that edge. Read data arrives one edge after the read strobe. The bench drives every strobe for exactly one cycle from the falling edge and samples `bus_rdata` at the next falling edge, which is the first point where the new byte is visible. For the hold check, it samples again several idle cycles later.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

    localparam logic [7:0] KEY_UNLOCK = 8'h87;
    localparam logic [7:0] KEY_LOCK   = 8'hAA;
    localparam logic [7:0] IDX_LDN    = 8'h07;
    localparam logic [7:0] IDX_CHIP   = 8'h20;
    localparam logic [7:0] IDX_ACT    = 8'h30;
    localparam logic [7:0] IDX_GEN0   = 8'hF0;
    localparam logic [7:0] LDN_WDOG   = 8'h08;
    localparam logic [7:0] BYTE_IDLE  = 8'hFF;

    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_HALF   = 2'd1,
        ST_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic       sel_data;
        logic       wr;
        logic       rd;
        logic [7:0] wdata;
    } bus_req_t;

    // True when idx falls inside the generic register window of n bytes.
    function automatic logic idx_is_gen(input logic [7:0] idx, input int n);
        return (int'(idx) >= int'(IDX_GEN0)) && (int'(idx) < int'(IDX_GEN0) + n);
    endfunction

endpackage

// File: rtl/kcp_key_seq.sv
module kcp_key_seq
    import kcp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       sel_data,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] index
);

    key_state_e st_q, st_d;
    logic [7:0] idx_q, idx_d;
    logic       idx_wr;

    always_comb begin
        idx_wr = wr && !sel_data;
        st_d   = st_q;
        idx_d  = idx_q;
        unique case (st_q)
            ST_LOCKED: begin
                if (idx_wr && wdata == KEY_UNLOCK) st_d = ST_HALF;
            end
            ST_HALF: begin
                // Any intervening write breaks the key pair.
                if (wr) st_d = (idx_wr && wdata == KEY_UNLOCK) ? ST_OPEN : ST_LOCKED;
            end
            ST_OPEN: begin
                if (idx_wr) begin
                    if (wdata == KEY_LOCK) st_d = ST_LOCKED;
                    else                   idx_d = wdata;
                end
            end
            default: st_d = ST_LOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_LOCKED;
            idx_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
        end
    end

    assign unlocked = (st_q == ST_OPEN);
    assign index    = idx_q;

endmodule

// File: rtl/kcp_dev_bank.sv
module kcp_dev_bank
    import kcp_pkg::*;
#(
    parameter int NUM_GEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sel,
    input  logic       wr_en,
    input  logic [7:0] index,
    input  logic [7:0] wdata,
    output logic       active,
    output logic       rd_hit,
    output logic [7:0] rd_val
);

    localparam int GW = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

    logic            act_q;
    logic [7:0]      gen_q [NUM_GEN];
    logic [7:0]      off;
    logic [GW-1:0]   goff;
    logic            is_gen;

    assign off    = index - IDX_GEN0;
    assign goff   = off[GW-1:0];
    assign is_gen = idx_is_gen(index, NUM_GEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            for (int i = 0; i < NUM_GEN; i++) gen_q[i] <= '0;
        end else if (sel && wr_en) begin
            if (index == IDX_ACT) act_q <= wdata[0];
            if (is_gen)           gen_q[goff] <= wdata;
        end
    end

    always_comb begin
        rd_hit = 1'b0;
        rd_val = BYTE_IDLE;
        if (index == IDX_ACT) begin
            rd_hit = 1'b1;
            rd_val = {7'b0, act_q};
        end else if (is_gen) begin
            rd_hit = 1'b1;
            rd_val = gen_q[goff];
        end
    end

    assign active = act_q;

endmodule

// File: rtl/kcp_cfg_regs.sv
module kcp_cfg_regs
    import kcp_pkg::*;
#(
    parameter int         NUM_DEV = 10,
    parameter int         NUM_GEN = 4,
    parameter logic [7:0] CHIP_ID = 8'hA5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               data_wr,
    input  logic [7:0]         index,
    input  logic [7:0]         wdata,
    output logic [7:0]         rd_val,
    output logic [7:0]         ldn,
    output logic [NUM_DEV-1:0] dev_active
);

    logic [7:0]         ldn_q;
    logic [NUM_DEV-1:0] bank_sel;
    logic [NUM_DEV-1:0] bank_hit;
    logic [7:0]         bank_val [NUM_DEV];

    always_ff @(posedge clk) begin
        if (rst)                              ldn_q <= '0;
        else if (data_wr && index == IDX_LDN) ldn_q <= wdata;
    end

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
        assign bank_sel[g] = (ldn_q == 8'(g));
        kcp_dev_bank #(.NUM_GEN(NUM_GEN)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .sel    (bank_sel[g]),
            .wr_en  (data_wr),
            .index  (index),
            .wdata  (wdata),
            .active (dev_active[g]),
            .rd_hit (bank_hit[g]),
            .rd_val (bank_val[g])
        );
    end

    always_comb begin
        rd_val = BYTE_IDLE;
        if (index == IDX_LDN) begin
            rd_val = ldn_q;
        end else if (index == IDX_CHIP) begin
            rd_val = CHIP_ID;
        end else begin
            for (int g = 0; g < NUM_DEV; g++) begin
                if (bank_sel[g] && bank_hit[g]) rd_val = bank_val[g];
            end
        end
    end

    assign ldn = ldn_q;

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import kcp_pkg::*;
#(
    parameter int         NUM_DEV = 10,
    parameter int         NUM_GEN = 4,
    parameter logic [7:0] CHIP_ID = 8'hA5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    output logic [NUM_DEV-1:0] dev_active
);

    bus_req_t   req;
    logic       unlocked_w;
    logic [7:0] index_w;
    logic [7:0] ldn_w;
    logic [7:0] cfg_val;
    logic [7:0] rdata_q;

    assign req = '{sel_data: bus_addr, wr: bus_wr, rd: bus_rd, wdata: bus_wdata};

    kcp_key_seq u_key (
        .clk      (clk),
        .rst      (rst),
        .wr       (req.wr),
        .sel_data (req.sel_data),
        .wdata    (req.wdata),
        .unlocked (unlocked_w),
        .index    (index_w)
    );

    kcp_cfg_regs #(
        .NUM_DEV (NUM_DEV),
        .NUM_GEN (NUM_GEN),
        .CHIP_ID (CHIP_ID)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .data_wr    (unlocked_w && req.wr && req.sel_data),
        .index      (index_w),
        .wdata      (req.wdata),
        .rd_val     (cfg_val),
        .ldn        (ldn_w),
        .dev_active (dev_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= BYTE_IDLE;
        end else if (req.rd) begin
            if (!unlocked_w)       rdata_q <= BYTE_IDLE;
            else if (req.sel_data) rdata_q <= cfg_val;
            else                   rdata_q <= index_w;
        end
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/kcp_checker.sv
module kcp_checker #(
    parameter int         NUM_DEV = 10,
    parameter logic [7:0] CHIP_ID = 8'hA5
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_addr,
    input logic               bus_wr,
    input logic               bus_rd,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic [NUM_DEV-1:0] dev_active,
    input logic               unlocked,
    input logic [7:0]         index,
    input logic [7:0]         ldn
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!unlocked && index == 8'h00 && ldn == 8'h00 &&
                 dev_active == '0 && bus_rdata == 8'hFF));

    assert_unlock_needs_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

    assert_locked_read_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !unlocked) |=> (bus_rdata == 8'hFF));

    assert_locked_no_effect_R4: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(dev_active) && $stable(ldn)));

    assert_lock_key_R5: assert property (@(posedge clk) disable iff (rst)
        (unlocked && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=>
        (!unlocked && $stable(index)));

    assert_chip_id_R8: assert property (@(posedge clk) disable iff (rst)
        (unlocked && bus_rd && bus_addr && index == 8'h20) |=> (bus_rdata == CHIP_ID));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind keyed_cfg_port kcp_checker #(
    .NUM_DEV (NUM_DEV),
    .CHIP_ID (CHIP_ID)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dev_active (dev_active),
    .unlocked   (unlocked_w),
    .index      (index_w),
    .ldn        (ldn_w)
);

// File: tb/sim_keyed_cfg_port.sv
module sim_keyed_cfg_port;

    localparam int NUM_DEV = 10;
    localparam logic [1:0] OP_WR = 2'd1;
    localparam logic [1:0] OP_RD = 2'd2;
    localparam logic IA = 1'b0;
    localparam logic DA = 1'b1;
    localparam int NVEC = 37;

    // {req[3:0], op[1:0], addr, wdata[7:0], expected[7:0]}
    localparam logic [22:0] VEC [NVEC] = '{
        {4'd4,  OP_RD, DA, 8'h00, 8'hFF},  // R4 locked read
        {4'd2,  OP_WR, IA, 8'h87, 8'h00},
        {4'd3,  OP_WR, IA, 8'h12, 8'h00},  // R3 breaks the pair
        {4'd3,  OP_WR, IA, 8'h87, 8'h00},
        {4'd3,  OP_RD, IA, 8'h00, 8'hFF},  // R3 still locked
        {4'd2,  OP_WR, IA, 8'h87, 8'h00},  // R2 unlock
        {4'd2,  OP_RD, IA, 8'h00, 8'h00},  // R2 served next cycle
        {4'd8,  OP_WR, IA, 8'h20, 8'h00},
        {4'd8,  OP_RD, DA, 8'h00, 8'hA5},  // R8
        {4'd8,  OP_WR, DA, 8'h33, 8'h00},
        {4'd8,  OP_RD, DA, 8'h00, 8'hA5},  // R8 write ignored
        {4'd7,  OP_WR, IA, 8'h07, 8'h00},
        {4'd7,  OP_WR, DA, 8'h08, 8'h00},
        {4'd7,  OP_RD, DA, 8'h00, 8'h08},  // R7
        {4'd9,  OP_WR, IA, 8'h30, 8'h00},
        {4'd9,  OP_WR, DA, 8'hFF, 8'h00},
        {4'd9,  OP_RD, DA, 8'h00, 8'h01},  // R9
        {4'd10, OP_WR, IA, 8'hF2, 8'h00},
        {4'd10, OP_WR, DA, 8'h5A, 8'h00},
        {4'd10, OP_RD, DA, 8'h00, 8'h5A},  // R10
        {4'd10, OP_WR, IA, 8'h07, 8'h00},
        {4'd10, OP_WR, DA, 8'h03, 8'h00},
        {4'd10, OP_WR, IA, 8'hF2, 8'h00},
        {4'd10, OP_RD, DA, 8'h00, 8'h00},  // R10 bank 3 separate
        {4'd9,  OP_WR, IA, 8'h30, 8'h00},
        {4'd9,  OP_RD, DA, 8'h00, 8'h00},  // R9 bank 3 inactive
        {4'd11, OP_WR, IA, 8'h07, 8'h00},
        {4'd11, OP_WR, DA, 8'h0C, 8'h00},
        {4'd11, OP_WR, IA, 8'hF2, 8'h00},
        {4'd11, OP_WR, DA, 8'h77, 8'h00},
        {4'd11, OP_RD, DA, 8'h00, 8'hFF},  // R11 out-of-range device
        {4'd11, OP_WR, IA, 8'h45, 8'h00},
        {4'd11, OP_RD, DA, 8'h00, 8'hFF},  // R11 unmapped index
        {4'd6,  OP_RD, IA, 8'h00, 8'h45},  // R6
        {4'd5,  OP_WR, IA, 8'hAA, 8'h00},
        {4'd5,  OP_RD, DA, 8'h00, 8'hFF},  // R5 locked again
        {4'd4,  OP_RD, IA, 8'h00, 8'hFF}   // R4
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_addr = 1'b0;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [7:0]         bus_wdata = 8'h00;
    logic [7:0]         bus_rdata;
    logic [NUM_DEV-1:0] dev_active;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    keyed_cfg_port u0 (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dev_active (dev_active)
    );

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            n_errors++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, 16'(bus_rdata), 16'h00FF);
        check(1, 16'(dev_active), 16'h0000);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [22:0] v;
            v = VEC[i];
            if (v[18:17] == OP_WR) begin
                bus_write(v[16], v[15:8]);
            end else begin
                bus_read(v[16], rv);
                check(int'(v[22:19]), 16'(rv), 16'(v[7:0]));
            end
        end

        // R9: watchdog bank activate bit appears on dev_active[8]
        check(9, 16'(dev_active), 16'h0100);

        // R4: writes while locked leave state untouched
        bus_write(DA, 8'h00);
        bus_write(IA, 8'h30);
        bus_write(DA, 8'h00);
        check(4, 16'(dev_active), 16'h0100);

        // R5: index survives a lock/unlock cycle
        bus_write(IA, 8'h87);
        bus_write(IA, 8'h87);
        bus_read(IA, rv);
        check(5, 16'(rv), 16'h0045);
        bus_write(IA, 8'h07);
        bus_read(DA, rv);
        check(4, 16'(rv), 16'h000C);

        // R12: read data holds through idle cycles
        repeat (4) @(negedge clk);
        check(12, 16'(bus_rdata), 16'h000C);

        // R10: bank 8 generic byte kept
        bus_write(DA, 8'h08);
        bus_write(IA, 8'hF2);
        bus_read(DA, rv);
        check(10, 16'(rv), 16'h005A);

        // R1: reset in mid-run
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, 16'(bus_rdata), 16'h00FF);
        check(1, 16'(dev_active), 16'h0000);
        bus_read(DA, rv);
        check(1, 16'(rv), 16'h00FF);

        // R3: a data-address write between key writes restarts the key
        bus_write(IA, 8'h87);
        bus_write(DA, 8'h87);
        bus_write(IA, 8'h87);
        bus_read(IA, rv);
        check(3, 16'(rv), 16'h00FF);
        bus_write(IA, 8'h87);
        bus_read(IA, rv);
        check(1, 16'(rv), 16'h0000);
        bus_write(IA, 8'h07);
        bus_read(DA, rv);
        check(1, 16'(rv), 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule